// File: doc/BRIEF.md
# Normalization Shift Amount Counter

This block measures how far a data word can be shifted left before its meaningful bits reach the top. It has two modes. In the unsigned mode it counts the zero bits above the highest set bit. In the signed mode it counts the redundant sign bits. This is the left shift that leaves the two most significant bits of a two's-complement value different from each other. Software and datapath logic use the count to normalize values before fixed-point or floating-point style arithmetic.

One operand and one mode bit are sampled on each rising clock edge. The count appears on a registered result port of full data width one cycle later, with zeros in the bits above the count field. A new operand can be applied on every cycle. The data width is a parameter and must be a power of two. The default is 32 bits.

Top module: `nsa_count`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count_o` becomes zero on that edge, whatever the operand and mode are.
- R2: The operand and mode sampled at one rising edge determine `count_o` right after that edge. A different operand may be applied on every cycle, and each result matches its own operand.
- R3: With `signed_mode_i` = 0 (unsigned mode), `count_o` equals the number of zero bits above the most significant set bit of the operand. An operand with bit 31 set gives 0.
- R4: In unsigned mode, an all-zero operand gives 32.
- R5: With `signed_mode_i` = 1 (signed mode), an operand with bit 31 set is bitwise inverted first. The result is then the leading-zero count of that value minus one.
- R6: In signed mode, both 0x00000000 and 0xFFFFFFFF give 31.
- R7: Signed results never exceed 31 and unsigned results never exceed 32. Bits 31 down to 6 of `count_o` are always zero.
- R8: The mode bit is honoured per cycle. The same operand applied in both modes on consecutive cycles gives each mode's own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| operand_i | input | 32 | Word whose normalization shift is measured |
| signed_mode_i | input | 1 | 1 = redundant sign bit count, 0 = leading zero count |
| count_o | output | 32 | Registered shift amount, upper bits zero |

## Verification
On every cycle, the bound checker enforces the result ranges of both modes. It also checks the fixed results for a zero operand in each mode, for an all-ones operand in signed mode, and the zero result for an unsigned operand whose top bit is set. Whether each individual count is exact can only be shown by the bench's scenarios. The bench sweeps every one-hot and every one-cold operand, the two all-equal words and a set of mixed patterns through both modes. It compares each result with an arithmetic model. These scenarios also cover the per-cycle mode changes and the reset behaviour.

// File: rtl/nsa_pkg.sv
package nsa_pkg;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } nsa_mode_e;

endpackage

// File: rtl/nsa_sign_fold.sv
module nsa_sign_fold #(
  parameter int W = 32
) (
  input  logic [W-1:0]       data_i,
  input  nsa_pkg::nsa_mode_e mode_i,
  output logic [W-1:0]       folded_o
);

  // Negative values in signed mode are inverted, so that redundant sign
  // bits always appear as leading zeros.
  always_comb begin
    if (mode_i == nsa_pkg::MODE_SIGNED && data_i[W-1]) begin
      folded_o = ~data_i;
    end else begin
      folded_o = data_i;
    end
  end

endmodule

// File: rtl/nsa_lzc_tree.sv
module nsa_lzc_tree #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] lz_o
);

  localparam int LV = $clog2(W);

  // node[l][i] holds the leading-zero count of group i at level l. Each
  // group spans 2**l bits, and group 0 is the most significant one.
  logic [CW-1:0] node [LV+1][W];

  always_comb begin
    for (int l = 0; l <= LV; l++) begin
      for (int i = 0; i < W; i++) begin
        node[l][i] = '0;
      end
    end
    for (int i = 0; i < W; i++) begin
      node[0][i] = bits_i[W-1-i] ? CW'(0) : CW'(1);
    end
    for (int l = 1; l <= LV; l++) begin
      for (int i = 0; i < W; i++) begin
        if (i < (W >> l)) begin
          if (node[l-1][2*i] == CW'(1 << (l-1))) begin
            node[l][i] = CW'(1 << (l-1)) + node[l-1][2*i+1];
          end else begin
            node[l][i] = node[l-1][2*i];
          end
        end
      end
    end
    lz_o = node[LV][0];
  end

endmodule

// File: rtl/nsa_adjust.sv
module nsa_adjust #(
  parameter int CW = 6
) (
  input  logic [CW-1:0]      lz_i,
  input  nsa_pkg::nsa_mode_e mode_i,
  output logic [CW-1:0]      amount_o
);

  // In signed mode the folded value always has a zero top bit, so lz_i is
  // at least 1. Subtracting one also yields W-1 for an all-zero folded word.
  always_comb begin
    if (mode_i == nsa_pkg::MODE_SIGNED) begin
      amount_o = lz_i - CW'(1);
    end else begin
      amount_o = lz_i;
    end
  end

endmodule

// File: rtl/nsa_count.sv
module nsa_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] operand_i,
  input  logic         signed_mode_i,
  output logic [W-1:0] count_o
);

  localparam int CW = $clog2(W) + 1;

  nsa_pkg::nsa_mode_e mode;
  logic [W-1:0]       folded;
  logic [CW-1:0]      lz;
  logic [CW-1:0]      amount;

  assign mode = signed_mode_i ? nsa_pkg::MODE_SIGNED : nsa_pkg::MODE_UNSIGNED;

  nsa_sign_fold #(.W(W)) u_fold (
    .data_i   (operand_i),
    .mode_i   (mode),
    .folded_o (folded)
  );

  nsa_lzc_tree #(.W(W), .CW(CW)) u_lzc (
    .bits_i (folded),
    .lz_o   (lz)
  );

  nsa_adjust #(.CW(CW)) u_adj (
    .lz_i     (lz),
    .mode_i   (mode),
    .amount_o (amount)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
    end else begin
      count_o <= {{(W-CW){1'b0}}, amount};
    end
  end

endmodule

// File: rtl/nsa_count_chk.sv
module nsa_count_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] operand_i,
  input logic         signed_mode_i,
  input logic [W-1:0] count_o
);

  a_r7_signed_range: assert property (@(posedge clk) disable iff (rst)
    signed_mode_i |=> (count_o <= W-1));

  a_r7_unsigned_range: assert property (@(posedge clk) disable iff (rst)
    !signed_mode_i |=> (count_o <= W));

  a_r4_zero_unsigned: assert property (@(posedge clk) disable iff (rst)
    (!signed_mode_i && operand_i == '0) |=> (count_o == W));

  a_r6_signed_flat: assert property (@(posedge clk) disable iff (rst)
    (signed_mode_i && (operand_i == '0 || operand_i == '1)) |=> (count_o == W-1));

  a_r3_top_bit_set: assert property (@(posedge clk) disable iff (rst)
    (!signed_mode_i && operand_i[W-1]) |=> (count_o == '0));

endmodule

bind nsa_count nsa_count_chk #(.W(W)) u_chk (.*);

// File: tb/nsa_count_bench.sv
`timescale 1ns/1ps
module nsa_count_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand_i = '0;
  logic        signed_mode_i = 1'b0;
  logic [31:0] count_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nsa_count #(.W(32)) u_nsa_count (
    .clk           (clk),
    .rst           (rst),
    .operand_i     (operand_i),
    .signed_mode_i (signed_mode_i),
    .count_o       (count_o)
  );

  function automatic int model(logic [31:0] v, bit sg);
    int n = 0;
    logic [31:0] x = (sg && v[31]) ? ~v : v;
    for (int i = 31; i >= 0; i--) begin
      if (x[i]) break;
      n++;
    end
    return sg ? n - 1 : n;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at a falling edge and sample at the next falling edge (R2).
  task automatic apply(string tag, logic [31:0] v, bit sg);
    @(negedge clk);
    operand_i     = v;
    signed_mode_i = sg;
    @(negedge clk);
    check(tag, count_o, 32'(model(v, sg)));
    check("R7", {26'd0, count_o[31:26] | 6'd0} & 32'hFFFF_FFC0 | (count_o & 32'hFFFF_FFC0), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset clears the result even with an operand that would give 32
    repeat (3) @(negedge clk);
    check("R1", count_o, 32'd0);
    rst = 1'b0;

    apply("R4", 32'h0000_0000, 1'b0);
    apply("R6", 32'h0000_0000, 1'b1);
    apply("R6", 32'hFFFF_FFFF, 1'b1);
    apply("R3", 32'hFFFF_FFFF, 1'b0);

    for (int b = 0; b < 32; b++) begin
      apply("R3", 32'd1 << b, 1'b0);
      apply("R5", 32'd1 << b, 1'b1);
      apply("R3", ~(32'd1 << b), 1'b0);
      apply("R5", ~(32'd1 << b), 1'b1);
    end

    // R2: back-to-back mixed patterns with a changing mode
    apply("R2", 32'h0001_2345, 1'b0);
    apply("R2", 32'hC000_0000, 1'b1);
    apply("R2", 32'h3FFF_0000, 1'b1);
    apply("R2", 32'hFFFE_8001, 1'b1);
    apply("R2", 32'h0000_00F0, 1'b0);

    // R8: the same operand in both modes on consecutive cycles
    apply("R8", 32'hF000_0000, 1'b0);
    apply("R8", 32'hF000_0000, 1'b1);
    apply("R8", 32'h0000_0400, 1'b1);
    apply("R8", 32'h0000_0400, 1'b0);

    // R1: a reset in the middle of a run clears the held result
    @(negedge clk);
    operand_i = 32'd0;
    signed_mode_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1", count_o, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R4", count_o, 32'd32);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule